// File: doc/BRIEF.md
# Video Processor CPU Register Port

This block is the CPU-side register window of a tile-based video processor. The CPU reaches eight byte-wide registers through a 3-bit register select. Through them it sets the control and mask bytes, reads the status byte, and reaches the sprite attribute memory through an address/data pair. Two registers share one first/second toggle. One builds the scroll position and the other builds a 15-bit temporary video address and a 3-bit fine horizontal offset. The last register is a data window that auto-increments.

The data window reaches three targets. Pattern memory and nametable memory sit outside the block. The 32-entry palette RAM sits inside it. External accesses go out on a request/acknowledge interface, and the CPU is held through `cpu_ready_o` until the acknowledge arrives. Palette and register accesses finish in the cycle they are presented. An access completes on a rising clock edge where `cpu_cs_i` and `cpu_ready_o` are both high. The CPU must hold select, direction and write data steady until then.

Registers with no read path return the last byte seen on the data bus. The renderer sets and clears status bits through pulse inputs. It takes the control, mask, fine-X, temporary and current address values from the outputs.

Top module: `vpu_cpu_port`

## Requirements
- R1: After reset these all read zero: control, mask, status, temporary address, current address, fine-X, the write toggle, the sprite address, the bus latch and the pattern read buffer. `cpu_ready_o` is high while no access is pending.
- R2: A write to select 0 (control) stores the byte and copies data[1:0] into temporary address bits 11:10. Every other temporary address bit is left unchanged.
- R3: With the toggle clear, a write to select 5 loads fine-X from data[2:0] and temp[4:0] from data[7:3], then sets the toggle. With the toggle set, the write loads temp[14:12] from data[2:0] and temp[9:5] from data[7:3], then clears the toggle.
- R4: With the toggle clear, a write to select 6 loads temp[13:8] from data[5:0], clears temp[14], keeps temp[7:0] and sets the toggle. With the toggle set, the write loads temp[7:0], copies the whole temporary address into the current address and clears the toggle.
- R5: A read of select 2 returns the status byte, then clears status bit 7 and the write toggle.
- R6: Every completed access through select 7 advances the 15-bit current address by 32 when control bit 2 is set, and by 1 when it is clear. The target is chosen from current address bits 13:0 only.
- R7: A select-7 read at an address below 0x2000 returns the read buffer, then reloads the buffer with the pattern byte fetched at that address. No other access changes the buffer.
- R8: Select-7 accesses from 0x2000 to 0x3EFF go to nametable memory and return the fetched byte directly. Select-7 writes below 0x3F00 drive `mem_we_o` high with the access address and byte.
- R9: A select-7 write at 0x3F00 to 0x3FFF stores into palette entry addr[4:0]. When addr[1:0] is zero, bit 4 of that index is forced to zero.
- R10: A select-7 read at 0x3F00 to 0x3FFF returns palette entry addr[4:0]. Bit 4 of that index is cleared when the index ANDed with 0x13 equals 0x10.
- R11: A select-4 write stores the byte at the sprite address (set by select 3), then increments that address modulo 256. A select-4 read returns the entry and leaves the address unchanged.
- R12: Writes to selects 0, 1, 5 and 6 and every completed read load the bus latch with the data byte. Writes to selects 3, 4 and 7 leave it unchanged. Reads of selects 0, 1, 3, 5 and 6 return the latch.
- R13: A select-7 access below 0x3F00 holds `cpu_ready_o` low and raises `mem_req_o` until `mem_ack_i`. The access completes on the acknowledge cycle, and `mem_addr_o` stays stable while the request is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_cs_i | input | 1 | CPU access strobe, held until ready |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_sel_i | input | 3 | Register select (CPU address modulo 8) |
| cpu_wdata_i | input | 8 | CPU write byte |
| cpu_rdata_o | output | 8 | CPU read byte, valid while ready |
| cpu_ready_o | output | 1 | Access completes at this edge when high |
| stat_set_i | input | 8 | Status bits to set, one-cycle pulses |
| stat_clr_i | input | 8 | Status bits to clear, one-cycle pulses |
| ctrl_o | output | 8 | Control byte |
| mask_o | output | 8 | Mask byte |
| fine_x_o | output | 3 | Fine horizontal offset |
| temp_addr_o | output | 15 | Temporary video address |
| vram_addr_o | output | 15 | Current video address |
| mem_req_o | output | 1 | External memory request |
| mem_we_o | output | 1 | External memory write |
| mem_addr_o | output | 14 | External memory address |
| mem_wdata_o | output | 8 | External memory write byte |
| mem_ack_i | input | 1 | External memory acknowledge |
| mem_rdata_i | input | 8 | External memory read byte |

## Verification
A wrong toggle state shows up at the next select-5 or select-6 write, which lands in the wrong temporary-address field on the following edge. It can hide until a status read or a second write exposes it, so the stimulus interleaves status reads between address writes. A stale or wrongly refilled read buffer is only visible one pattern read later, and a wrong increment only at the next data access or on `vram_addr_o`. Palette index folding is checked by writing through a mirrored index and reading back through the base index and the other way round.

// File: rtl/vpu_port_pkg.sv
package vpu_port_pkg;

    localparam int VA_W  = 15;
    localparam int MA_W  = 14;
    localparam int FX_W  = 3;
    localparam logic [MA_W-1:0] NT_BASE  = 14'h2000;
    localparam logic [MA_W-1:0] PAL_BASE = 14'h3F00;

    typedef enum logic [2:0] {
        SEL_CTRL = 3'd0,
        SEL_MASK = 3'd1,
        SEL_STAT = 3'd2,
        SEL_SPRA = 3'd3,
        SEL_SPRD = 3'd4,
        SEL_SCRL = 3'd5,
        SEL_ADDR = 3'd6,
        SEL_DATA = 3'd7
    } reg_sel_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_WAIT = 1'b1
    } xfer_ph_e;

    // write side folds bit 4 whenever bits 1:0 are zero
    function automatic logic [4:0] pal_wr_fold(input logic [4:0] idx);
        return (idx[1:0] == 2'b00) ? {1'b0, idx[3:0]} : idx;
    endfunction

    // read side folds bit 4 only for the four backdrop aliases
    function automatic logic [4:0] pal_rd_fold(input logic [4:0] idx);
        return ((idx & 5'h13) == 5'h10) ? {1'b0, idx[3:0]} : idx;
    endfunction

endpackage

// File: rtl/vpu_addr_regs.sv
module vpu_addr_regs
    import vpu_port_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctrl_wr,
    input  logic            scrl_wr,
    input  logic            addr_wr,
    input  logic            tog_clr,
    input  logic            step_en,
    input  logic            step_wide,
    input  logic [7:0]      wdata,
    output logic [VA_W-1:0] temp_o,
    output logic [VA_W-1:0] vram_o,
    output logic [FX_W-1:0] fine_x_o
);

    typedef struct packed {
        logic [VA_W-1:0] temp;
        logic [VA_W-1:0] vram;
        logic [FX_W-1:0] fx;
        logic            tog;
    } areg_t;

    areg_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (ctrl_wr) begin
            r_d.temp[11:10] = wdata[1:0];
        end
        if (scrl_wr) begin
            if (!r_q.tog) begin
                r_d.fx        = wdata[2:0];
                r_d.temp[4:0] = wdata[7:3];
            end else begin
                r_d.temp[14:12] = wdata[2:0];
                r_d.temp[9:5]   = wdata[7:3];
            end
            r_d.tog = ~r_q.tog;
        end
        if (addr_wr) begin
            if (!r_q.tog) begin
                r_d.temp[14]   = 1'b0;
                r_d.temp[13:8] = wdata[5:0];
            end else begin
                r_d.temp[7:0] = wdata;
                r_d.vram      = {r_q.temp[14:8], wdata};
            end
            r_d.tog = ~r_q.tog;
        end
        if (step_en) begin
            r_d.vram = r_q.vram + (step_wide ? VA_W'(32) : VA_W'(1));
        end
        if (tog_clr) begin
            r_d.tog = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign temp_o   = r_q.temp;
    assign vram_o   = r_q.vram;
    assign fine_x_o = r_q.fx;

    AST_ADDR_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_wr && r_q.tog) |=> (vram_o == {$past(temp_o[14:8]), $past(wdata)})); // R4
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !addr_wr) |=> (vram_o == $past(vram_o) + ($past(step_wide) ? VA_W'(32) : VA_W'(1)))); // R6
    AST_TOG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (tog_clr && !scrl_wr && !addr_wr) |=> !r_q.tog); // R5

endmodule

// File: rtl/vpu_sprite_mem.sv
module vpu_sprite_mem #(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_wr,
    input  logic          data_wr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);

    typedef struct packed {
        logic [AW-1:0] ptr;
    } sreg_t;

    sreg_t      s_q, s_d;
    logic [7:0] mem_q [DEPTH];

    always_comb begin
        s_d = s_q;
        if (addr_wr) begin
            s_d.ptr = wdata[AW-1:0];
        end else if (data_wr) begin
            s_d.ptr = s_q.ptr + AW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (data_wr) begin
            mem_q[s_q.ptr] <= wdata;
        end
    end

    assign rdata = mem_q[s_q.ptr];

    AST_SPR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !addr_wr) |=> (s_q.ptr == $past(s_q.ptr) + AW'(1))); // R11
    AST_SPR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_wr && !addr_wr) |=> $stable(s_q.ptr)); // R11

endmodule

// File: rtl/vpu_palette.sv
module vpu_palette
    import vpu_port_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] idx,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);

    logic [7:0]    pal_q [ENTRIES];
    logic [IW-1:0] wr_idx, rd_idx;

    always_comb begin
        wr_idx = IW'(pal_wr_fold(5'(idx)));
        rd_idx = IW'(pal_rd_fold(5'(idx)));
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            pal_q[wr_idx] <= wdata;
        end
    end

    assign rdata = pal_q[rd_idx];

    AST_PAL_FOLD: assert property (@(posedge clk)
        (idx[1:0] == 2'b00) |-> (wr_idx[4] == 1'b0)); // R9

endmodule

// File: rtl/vpu_cpu_port.sv
module vpu_cpu_port
    import vpu_port_pkg::*;
#(
    parameter int SPR_DEPTH   = 256,
    parameter int PAL_ENTRIES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_cs_i,
    input  logic             cpu_we_i,
    input  logic [2:0]       cpu_sel_i,
    input  logic [7:0]       cpu_wdata_i,
    output logic [7:0]       cpu_rdata_o,
    output logic             cpu_ready_o,
    input  logic [7:0]       stat_set_i,
    input  logic [7:0]       stat_clr_i,
    output logic [7:0]       ctrl_o,
    output logic [7:0]       mask_o,
    output logic [FX_W-1:0]  fine_x_o,
    output logic [VA_W-1:0]  temp_addr_o,
    output logic [VA_W-1:0]  vram_addr_o,
    output logic             mem_req_o,
    output logic             mem_we_o,
    output logic [MA_W-1:0]  mem_addr_o,
    output logic [7:0]       mem_wdata_o,
    input  logic             mem_ack_i,
    input  logic [7:0]       mem_rdata_i
);

    localparam int PIW = $clog2(PAL_ENTRIES);

    typedef struct packed {
        logic [7:0] ctrl;
        logic [7:0] mask;
        logic [7:0] stat;
        logic [7:0] obus;
        logic [7:0] rbuf;
        xfer_ph_e   ph;
    } preg_t;

    preg_t      p_q, p_d;
    reg_sel_e   sel;
    logic [MA_W-1:0] acc_addr;
    logic       tgt_pal, tgt_pat, ext_need;
    logic       done, rd_done, wr_done;
    logic [7:0] spr_rdata, pal_rdata, rdata;
    logic       obus_wr;

    always_comb begin
        sel      = reg_sel_e'(cpu_sel_i);
        acc_addr = vram_addr_o[MA_W-1:0];
        tgt_pal  = (acc_addr >= PAL_BASE);
        tgt_pat  = (acc_addr < NT_BASE);
        ext_need = cpu_cs_i && (sel == SEL_DATA) && !tgt_pal;
        cpu_ready_o = (p_q.ph == PH_WAIT) ? mem_ack_i : !ext_need;
        done     = cpu_cs_i && cpu_ready_o;
        rd_done  = done && !cpu_we_i;
        wr_done  = done && cpu_we_i;
        obus_wr  = (sel == SEL_CTRL) || (sel == SEL_MASK) ||
                   (sel == SEL_SCRL) || (sel == SEL_ADDR);
    end

    always_comb begin
        unique case (sel)
            SEL_STAT: rdata = p_q.stat;
            SEL_SPRD: rdata = spr_rdata;
            SEL_DATA: rdata = tgt_pal ? pal_rdata : (tgt_pat ? p_q.rbuf : mem_rdata_i);
            default:  rdata = p_q.obus;
        endcase
    end

    always_comb begin
        p_d = p_q;
        unique case (p_q.ph)
            PH_IDLE: if (ext_need) p_d.ph = PH_WAIT;
            PH_WAIT: if (mem_ack_i) p_d.ph = PH_IDLE;
            default: p_d.ph = PH_IDLE;
        endcase
        p_d.stat = p_q.stat & ~stat_clr_i;
        if (rd_done && sel == SEL_STAT) begin
            p_d.stat[7] = 1'b0;
        end
        p_d.stat = p_d.stat | stat_set_i;
        if (wr_done) begin
            if (sel == SEL_CTRL) p_d.ctrl = cpu_wdata_i;
            if (sel == SEL_MASK) p_d.mask = cpu_wdata_i;
            if (obus_wr)         p_d.obus = cpu_wdata_i;
        end
        if (rd_done) begin
            p_d.obus = rdata;
            if (sel == SEL_DATA && tgt_pat) begin
                p_d.rbuf = mem_rdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    vpu_addr_regs u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (wr_done && sel == SEL_CTRL),
        .scrl_wr   (wr_done && sel == SEL_SCRL),
        .addr_wr   (wr_done && sel == SEL_ADDR),
        .tog_clr   (rd_done && sel == SEL_STAT),
        .step_en   (done && sel == SEL_DATA),
        .step_wide (p_q.ctrl[2]),
        .wdata     (cpu_wdata_i),
        .temp_o    (temp_addr_o),
        .vram_o    (vram_addr_o),
        .fine_x_o  (fine_x_o)
    );

    vpu_sprite_mem #(.DEPTH(SPR_DEPTH)) u_spr (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_wr (wr_done && sel == SEL_SPRA),
        .data_wr (wr_done && sel == SEL_SPRD),
        .wdata   (cpu_wdata_i),
        .rdata   (spr_rdata)
    );

    vpu_palette #(.ENTRIES(PAL_ENTRIES)) u_pal (
        .clk   (clk),
        .wr_en (wr_done && sel == SEL_DATA && tgt_pal),
        .idx   (acc_addr[PIW-1:0]),
        .wdata (cpu_wdata_i),
        .rdata (pal_rdata)
    );

    assign cpu_rdata_o = rdata;
    assign ctrl_o      = p_q.ctrl;
    assign mask_o      = p_q.mask;
    assign mem_req_o   = (p_q.ph == PH_WAIT);
    assign mem_we_o    = cpu_we_i;
    assign mem_addr_o  = acc_addr;
    assign mem_wdata_o = cpu_wdata_i;

    AST_WAIT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |-> !cpu_ready_o); // R13
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o))); // R13
    AST_STAT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && sel == SEL_STAT && !stat_set_i[7]) |=> !p_q.stat[7]); // R5
    AST_OBUS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && obus_wr) |=> (p_q.obus == $past(cpu_wdata_i))); // R12
    AST_BUF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_done && sel == SEL_DATA && tgt_pat) |=> $stable(p_q.rbuf)); // R7

endmodule

// File: tb/tb_vpu_cpu_port.sv
module tb_vpu_cpu_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_cs = 1'b0, cpu_we = 1'b0;
    logic [2:0]  cpu_sel = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_ready;
    logic [7:0]  stat_set = '0, stat_clr = '0;
    logic [7:0]  ctrl, mask;
    logic [2:0]  fine_x;
    logic [14:0] temp_addr, vram_addr;
    logic        mem_req, mem_we;
    logic [13:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = '0;

    int n_chk = 0, n_bad = 0;
    logic [13:0] log_addr = '0;
    logic [7:0]  log_data = '0;
    logic        stalled;
    logic [7:0]  rd;

    always #2 clk = ~clk;

    vpu_cpu_port dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_cs_i(cpu_cs), .cpu_we_i(cpu_we), .cpu_sel_i(cpu_sel),
        .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata), .cpu_ready_o(cpu_ready),
        .stat_set_i(stat_set), .stat_clr_i(stat_clr),
        .ctrl_o(ctrl), .mask_o(mask), .fine_x_o(fine_x),
        .temp_addr_o(temp_addr), .vram_addr_o(vram_addr),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
    );

    function automatic logic [7:0] ext_byte(input logic [13:0] a);
        return a[7:0] ^ {2'b00, a[13:8]};
    endfunction

    // external memory model: acknowledges one cycle after the request
    always @(negedge clk) begin
        mem_ack   <= mem_req && !mem_ack;
        mem_rdata <= ext_byte(mem_addr);
        if (mem_req && !mem_ack && mem_we) begin
            log_addr <= mem_addr;
            log_data <= mem_wdata;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic [2:0] s, input logic w, input logic [7:0] d);
        stalled = 1'b0;
        @(negedge clk);
        cpu_cs = 1'b1; cpu_we = w; cpu_sel = s; cpu_wdata = d;
        forever begin
            #1;
            if (cpu_ready) begin
                rd = cpu_rdata;
                @(posedge clk);
                break;
            end
            stalled = 1'b1;
            @(negedge clk);
        end
        #1 cpu_cs = 1'b0;
    endtask

    // {req, sel, we, wdata, chk, exp}
    localparam int NV = 45;
    localparam logic [24:0] VEC [NV] = '{
        {4'd11, 3'd3, 1'b1, 8'hFE, 1'b0, 8'h00}, // R11 sprite ptr FE
        {4'd11, 3'd4, 1'b1, 8'h11, 1'b0, 8'h00},
        {4'd11, 3'd4, 1'b1, 8'h22, 1'b0, 8'h00}, // ptr wraps to 00
        {4'd11, 3'd3, 1'b1, 8'hFF, 1'b0, 8'h00},
        {4'd11, 3'd4, 1'b0, 8'h00, 1'b1, 8'h22},
        {4'd11, 3'd4, 1'b0, 8'h00, 1'b1, 8'h22}, // R11 read keeps ptr
        {4'd11, 3'd4, 1'b1, 8'h33, 1'b0, 8'h00},
        {4'd11, 3'd3, 1'b1, 8'hFE, 1'b0, 8'h00},
        {4'd11, 3'd4, 1'b0, 8'h00, 1'b1, 8'h11},
        {4'd12, 3'd0, 1'b0, 8'h00, 1'b1, 8'h11}, // R12 latch from read
        {4'd12, 3'd1, 1'b1, 8'h5A, 1'b0, 8'h00},
        {4'd12, 3'd3, 1'b0, 8'h00, 1'b1, 8'h5A},
        {4'd12, 3'd4, 1'b1, 8'h44, 1'b0, 8'h00}, // does not touch latch
        {4'd12, 3'd5, 1'b0, 8'h00, 1'b1, 8'h5A},
        {4'd5,  3'd2, 1'b0, 8'h00, 1'b1, 8'h00}, // R5 status zero
        {4'd12, 3'd6, 1'b0, 8'h00, 1'b1, 8'h00},
        {4'd12, 3'd3, 1'b1, 8'h77, 1'b0, 8'h00},
        {4'd12, 3'd1, 1'b0, 8'h00, 1'b1, 8'h00},
        {4'd9,  3'd6, 1'b1, 8'h3F, 1'b0, 8'h00}, // R9 palette 3F00
        {4'd9,  3'd6, 1'b1, 8'h00, 1'b0, 8'h00},
        {4'd9,  3'd7, 1'b1, 8'h0A, 1'b0, 8'h00},
        {4'd9,  3'd7, 1'b1, 8'h01, 1'b0, 8'h00},
        {4'd9,  3'd6, 1'b1, 8'h3F, 1'b0, 8'h00},
        {4'd9,  3'd6, 1'b1, 8'h10, 1'b0, 8'h00},
        {4'd9,  3'd7, 1'b1, 8'h2B, 1'b0, 8'h00}, // 3F10 folds onto 3F00
        {4'd9,  3'd7, 1'b1, 8'h4D, 1'b0, 8'h00}, // 3F11 no fold
        {4'd9,  3'd6, 1'b1, 8'h3F, 1'b0, 8'h00},
        {4'd9,  3'd6, 1'b1, 8'h00, 1'b0, 8'h00},
        {4'd9,  3'd7, 1'b0, 8'h00, 1'b1, 8'h2B}, // R9
        {4'd6,  3'd7, 1'b0, 8'h00, 1'b1, 8'h01}, // R6 +1 step
        {4'd10, 3'd6, 1'b1, 8'h3F, 1'b0, 8'h00},
        {4'd10, 3'd6, 1'b1, 8'h10, 1'b0, 8'h00},
        {4'd10, 3'd7, 1'b0, 8'h00, 1'b1, 8'h2B}, // R10 read fold
        {4'd10, 3'd7, 1'b0, 8'h00, 1'b1, 8'h4D},
        {4'd12, 3'd0, 1'b0, 8'h00, 1'b1, 8'h4D},
        {4'd7,  3'd6, 1'b1, 8'h12, 1'b0, 8'h00}, // R7 pattern 1234
        {4'd7,  3'd6, 1'b1, 8'h34, 1'b0, 8'h00},
        {4'd7,  3'd7, 1'b0, 8'h00, 1'b1, 8'h00},
        {4'd7,  3'd7, 1'b0, 8'h00, 1'b1, 8'h26},
        {4'd8,  3'd6, 1'b1, 8'h23, 1'b0, 8'h00}, // R8 nametable 23C0
        {4'd8,  3'd6, 1'b1, 8'hC0, 1'b0, 8'h00},
        {4'd8,  3'd7, 1'b0, 8'h00, 1'b1, 8'hE3},
        {4'd8,  3'd7, 1'b0, 8'h00, 1'b1, 8'hE2},
        {4'd7,  3'd6, 1'b1, 8'h00, 1'b0, 8'h00},
        {4'd7,  3'd6, 1'b1, 8'h00, 1'b0, 8'h00}
    };

    initial begin : watchdog
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 ctrl", ctrl, 0);
        check("R1 temp", temp_addr, 0);
        check("R1 vram", vram_addr, 0);
        check("R1 fine_x", fine_x, 0);
        check("R1 ready", cpu_ready, 1);

        for (int i = 0; i < NV; i++) begin
            acc(VEC[i][20:18], VEC[i][17], VEC[i][16:9]);
            if (VEC[i][8]) check($sformatf("R%0d vec%0d", VEC[i][24:21], i), rd, VEC[i][7:0]);
        end
        // R7 buffer survived the nametable reads
        acc(3'd7, 1'b0, 8'h00);
        check("R7 buffer kept", rd, 8'h27);
        acc(3'd1, 1'b0, 8'h00);
        check("R12 latch after data read", rd, 8'h27);

        // R2 control into temp[11:10]
        acc(3'd0, 1'b1, 8'h03);
        check("R2 temp", temp_addr, 15'h0C00);
        // R3 scroll pair
        acc(3'd5, 1'b1, 8'hAF);
        check("R3 fine_x", fine_x, 3'd7);
        check("R3 temp first", temp_addr, 15'h0C15);
        acc(3'd5, 1'b1, 8'h5E);
        check("R3 temp second", temp_addr, 15'h6D75);
        // R4 first write clears bit 14; R5 status read resets toggle
        acc(3'd6, 1'b1, 8'h3F);
        check("R4 temp hi", temp_addr, 15'h3F75);
        acc(3'd2, 1'b0, 8'h00);
        acc(3'd6, 1'b1, 8'h12);
        check("R5 toggle cleared", temp_addr, 15'h1275);
        acc(3'd6, 1'b1, 8'h80);
        check("R4 vram copy", vram_addr, 15'h1280);

        // R5 status bit 7
        @(negedge clk); stat_set = 8'h80;
        @(negedge clk); stat_set = 8'h00;
        acc(3'd2, 1'b0, 8'h00);
        check("R5 status set", rd, 8'h80);
        acc(3'd2, 1'b0, 8'h00);
        check("R5 status cleared", rd, 8'h00);

        // R6 step 32
        acc(3'd0, 1'b1, 8'h04);
        acc(3'd6, 1'b1, 8'h3F);
        acc(3'd6, 1'b1, 8'h00);
        acc(3'd7, 1'b0, 8'h00);
        check("R9 palette base", rd, 8'h2B);
        check("R13 palette no stall", stalled, 0);
        check("R6 step 32", vram_addr, 15'h3F20);

        // R8/R13 external write
        acc(3'd6, 1'b1, 8'h05);
        acc(3'd6, 1'b1, 8'h67);
        acc(3'd7, 1'b1, 8'h99);
        check("R13 stalled", stalled, 1);
        check("R8 write addr", log_addr, 14'h0567);
        check("R8 write data", log_data, 8'h99);
        check("R6 step after write", vram_addr, 15'h0587);

        // R6 wrap past 3FFF, access uses low 14 bits
        acc(3'd0, 1'b1, 8'h00);
        acc(3'd6, 1'b1, 8'h3F);
        acc(3'd6, 1'b1, 8'hFF);
        acc(3'd7, 1'b1, 8'h77);
        check("R6 vram 4000", vram_addr, 15'h4000);
        acc(3'd7, 1'b1, 8'h88);
        check("R6 low14 addr", log_addr, 14'h0000);
        check("R8 data 88", log_data, 8'h88);
        acc(3'd6, 1'b1, 8'h3F);
        acc(3'd6, 1'b1, 8'h1F);
        acc(3'd7, 1'b0, 8'h00);
        check("R10 entry 1F unfolded", rd, 8'h77);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule